// File: doc/BRIEF.md
# Stored-Program Machine Control Sequencer

This block is the control unit of a small byte-oriented stored-program machine. It steps the machine through fetch, decode and execute. For each state it drives the load, increment and select strobes that the datapath needs. The datapath holds the program counter, the instruction register, the address register, a small general register file, the zero flag, the ALU and the memory. None of these is part of this block. The sequencer only sees the opcode and the register fields of the instruction register, plus the zero flag.

Single-byte instructions complete in the decode state (no-op) or in one execute state (ALU operations). Two-byte instructions carry a memory address in the second byte. They step through two extra states: the first picks up the address byte and moves the program counter past it, and the second does the memory read, the memory write or the branch. The conditional branch uses the zero flag to choose between the branch path and simply skipping its address byte. An opcode outside the instruction set traps the sequencer in a halt state, and only reset releases it.

Top module: `spm_sequencer`

## Requirements
- R1: On reset (rst_n low, asynchronous) the state code is 0 (idle) and every strobe and select output is 0. The first rising clock edge after release moves to fetch1. In idle and in halt all strobes are low and both selects are 0.
- R2: State codes on state_code: idle 0, fetch1 1, fetch2 2, decode 3, execute 4, read-addr 5, read-data 6, write-addr 7, write-data 8, branch-addr 9, branch-target 10, halt 11. A select not named for a state is 0. In fetch1, bus1_sel is 4 (program counter) and ar_load is high. In fetch2, bus2_sel is 2 (memory), ir_load and pc_inc are high. Fetch1 moves to fetch2, and fetch2 moves to decode.
- R3: Opcodes: 0 no-op, 1 add, 2 subtract, 3 and, 4 not, 5 read, 6 write, 7 branch, 8 branch-if-zero. A no-op asserts nothing in decode and returns to fetch1.
- R4: For opcodes 1 to 4, decode drives bus1_sel with the source field and goes to execute. In execute, bus1_sel equals the source field and bus2_sel is 0 (ALU). reg_load has only the bit selected by the destination field set, and zf_load is high. Execute then returns to fetch1. zf_load is never high in any other state.
- R5: For opcodes 5 to 7, and for a taken branch-if-zero, decode drives bus1_sel=4 and ar_load. Each address state (5, 7, 9) drives bus2_sel=2, ar_load and pc_inc.
- R6: Read-data drives bus2_sel=2 and sets the reg_load bit of the destination field, then returns to fetch1.
- R7: Write-data drives bus1_sel with the source field and mem_we, then returns to fetch1. mem_we is high only in the cycle after write-addr.
- R8: Branch-target drives bus2_sel=2 and pc_load, then returns to fetch1.
- R9: Branch-if-zero is taken when zero_flag is 1 and then follows the branch states. When zero_flag is 0, decode asserts only pc_inc and returns to fetch1.
- R10: Opcodes 9 to 15 go from decode to halt. Decode asserts nothing for them. Halt drives halted high with all other strobes low, and it stays there for any opcode or flag until reset.
- R11: At most one reg_load bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| ir_src | input | 2 | Source register field |
| ir_dst | input | 2 | Destination register field |
| zero_flag | input | 1 | Zero flag from the datapath |
| pc_load | output | 1 | Load program counter from bus 2 |
| pc_inc | output | 1 | Increment program counter |
| ir_load | output | 1 | Load instruction register from bus 2 |
| ar_load | output | 1 | Load address register |
| reg_load | output | 4 | One-hot load of a general register from bus 2 |
| zf_load | output | 1 | Capture zero flag from the ALU |
| bus1_sel | output | 3 | Bus 1 source: 0..3 general register, 4 program counter |
| bus2_sel | output | 2 | Bus 2 source: 0 ALU, 1 bus 1, 2 memory |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Trap indication |
| state_code | output | 4 | Current state code |

## Verification
The bench follows every opcode class through its full state path, cycle by cycle. It checks the whole strobe vector in each state. A sequencer that skipped or reordered the address-byte states, or that incremented the program counter in the wrong cycle, would show up as a mismatch there. The conditional branch is run with the flag both set and clear. A wrong polarity would branch when it should skip, and a missing increment would leave the program counter on the address byte. Opcodes 9, 12 and 15 are driven into decode, and the inputs are then changed while in halt. A sequencer that treated them as a no-op or that left halt on its own would be caught. The tests also check that reset still recovers from halt.

// File: rtl/spm_ctl_pkg.sv
package spm_ctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_FET1  = 4'd1,
      ST_FET2  = 4'd2,
      ST_DEC   = 4'd3,
      ST_EXE   = 4'd4,
      ST_RDA   = 4'd5,
      ST_RDD   = 4'd6,
      ST_WRA   = 4'd7,
      ST_WRD   = 4'd8,
      ST_BRA   = 4'd9,
      ST_BRT   = 4'd10,
      ST_HALT  = 4'd11
   } seq_state_t;

   typedef enum logic [1:0] {
      B2_ALU  = 2'd0,
      B2_BUS1 = 2'd1,
      B2_MEM  = 2'd2
   } bus2_src_t;

   typedef enum logic [2:0] {
      CL_NOP,
      CL_ALU,
      CL_RD,
      CL_WR,
      CL_BR,
      CL_SKIP,
      CL_BAD
   } op_class_t;

   localparam logic [3:0] OP_NOP = 4'd0;
   localparam logic [3:0] OP_ADD = 4'd1;
   localparam logic [3:0] OP_SUB = 4'd2;
   localparam logic [3:0] OP_AND = 4'd3;
   localparam logic [3:0] OP_NOT = 4'd4;
   localparam logic [3:0] OP_RD  = 4'd5;
   localparam logic [3:0] OP_WR  = 4'd6;
   localparam logic [3:0] OP_BR  = 4'd7;
   localparam logic [3:0] OP_BRZ = 4'd8;

endpackage

// File: rtl/spm_opdecode.sv
module spm_opdecode
   import spm_ctl_pkg::*;
#(
   parameter int OPW        = 4,
   parameter bit BRZ_ON_SET = 1'b1
) (
   input  logic [OPW-1:0] opcode,
   input  logic           zero_flag,
   output op_class_t      op_class
);

   logic       hi_bits;
   logic [3:0] base_op;
   logic       cond_true;

   generate
      if (OPW < 4) begin : g_width_bad
         $error("spm_opdecode: OPW must be at least 4");
      end
      if (OPW > 4) begin : g_wide
         assign hi_bits = |opcode[OPW-1:4];
      end else begin : g_narrow
         assign hi_bits = 1'b0;
      end
      if (BRZ_ON_SET) begin : g_pol_set
         assign cond_true = zero_flag;
      end else begin : g_pol_clr
         assign cond_true = ~zero_flag;
      end
   endgenerate

   assign base_op = opcode[3:0];

   always_comb begin
      op_class = CL_BAD;
      if (!hi_bits) begin
         unique case (base_op)
            OP_NOP:                         op_class = CL_NOP;
            OP_ADD, OP_SUB, OP_AND, OP_NOT: op_class = CL_ALU;
            OP_RD:                          op_class = CL_RD;
            OP_WR:                          op_class = CL_WR;
            OP_BR:                          op_class = CL_BR;
            OP_BRZ:                         op_class = cond_true ? CL_BR : CL_SKIP;
            default:                        op_class = CL_BAD;
         endcase
      end
   end

endmodule

// File: rtl/spm_nextstate.sv
module spm_nextstate
   import spm_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  op_class_t  op_class,
   output seq_state_t state
);

   seq_state_t nxt;

   always_comb begin
      nxt = ST_HALT;
      unique case (state)
         ST_IDLE: nxt = ST_FET1;
         ST_FET1: nxt = ST_FET2;
         ST_FET2: nxt = ST_DEC;
         ST_DEC: begin
            unique case (op_class)
               CL_NOP, CL_SKIP: nxt = ST_FET1;
               CL_ALU:          nxt = ST_EXE;
               CL_RD:           nxt = ST_RDA;
               CL_WR:           nxt = ST_WRA;
               CL_BR:           nxt = ST_BRA;
               default:         nxt = ST_HALT;
            endcase
         end
         ST_EXE:  nxt = ST_FET1;
         ST_RDA:  nxt = ST_RDD;
         ST_RDD:  nxt = ST_FET1;
         ST_WRA:  nxt = ST_WRD;
         ST_WRD:  nxt = ST_FET1;
         ST_BRA:  nxt = ST_BRT;
         ST_BRT:  nxt = ST_FET1;
         ST_HALT: nxt = ST_HALT;
         default: nxt = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |=> (state == ST_HALT));

   // R1
   idle_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (state == ST_FET1));

endmodule

// File: rtl/spm_strobes.sv
module spm_strobes
   import spm_ctl_pkg::*;
#(
   parameter int REGW = 2,
   localparam int NREG = 1 << REGW,
   localparam int SELW = $clog2(NREG + 1)
) (
   input  seq_state_t      state,
   input  op_class_t       op_class,
   input  logic [REGW-1:0] src,
   input  logic [REGW-1:0] dst,
   output logic            pc_load,
   output logic            pc_inc,
   output logic            ir_load,
   output logic            ar_load,
   output logic [NREG-1:0] reg_load,
   output logic            zf_load,
   output logic [SELW-1:0] bus1_sel,
   output bus2_src_t       bus2_sel,
   output logic            mem_we,
   output logic            halted
);

   localparam logic [SELW-1:0] SEL_PC = SELW'(NREG);

   logic            dst_we;
   logic [SELW-1:0] src_sel;

   generate
      if (REGW < 1) begin : g_regw_bad
         $error("spm_strobes: REGW must be at least 1");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_rld
         assign reg_load[g] = dst_we && (dst == REGW'(g));
      end
   endgenerate

   assign src_sel = SELW'(src);

   always_comb begin
      pc_load  = 1'b0;
      pc_inc   = 1'b0;
      ir_load  = 1'b0;
      ar_load  = 1'b0;
      dst_we   = 1'b0;
      zf_load  = 1'b0;
      bus1_sel = '0;
      bus2_sel = B2_ALU;
      mem_we   = 1'b0;
      halted   = 1'b0;
      unique case (state)
         ST_FET1: begin
            bus1_sel = SEL_PC;
            ar_load  = 1'b1;
         end
         ST_FET2: begin
            bus2_sel = B2_MEM;
            ir_load  = 1'b1;
            pc_inc   = 1'b1;
         end
         ST_DEC: begin
            unique case (op_class)
               CL_ALU: bus1_sel = src_sel;
               CL_RD, CL_WR, CL_BR: begin
                  bus1_sel = SEL_PC;
                  ar_load  = 1'b1;
               end
               CL_SKIP: pc_inc = 1'b1;
               default: ;
            endcase
         end
         ST_EXE: begin
            bus1_sel = src_sel;
            bus2_sel = B2_ALU;
            dst_we   = 1'b1;
            zf_load  = 1'b1;
         end
         ST_RDA, ST_WRA, ST_BRA: begin
            bus2_sel = B2_MEM;
            ar_load  = 1'b1;
            pc_inc   = 1'b1;
         end
         ST_RDD: begin
            bus2_sel = B2_MEM;
            dst_we   = 1'b1;
         end
         ST_WRD: begin
            bus1_sel = src_sel;
            mem_we   = 1'b1;
         end
         ST_BRT: begin
            bus2_sel = B2_MEM;
            pc_load  = 1'b1;
         end
         ST_HALT: halted = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/spm_sequencer.sv
module spm_sequencer
   import spm_ctl_pkg::*;
#(
   parameter int OPW        = 4,
   parameter int REGW       = 2,
   parameter bit BRZ_ON_SET = 1'b1,
   localparam int NREG = 1 << REGW,
   localparam int SELW = $clog2(NREG + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OPW-1:0]  ir_opcode,
   input  logic [REGW-1:0] ir_src,
   input  logic [REGW-1:0] ir_dst,
   input  logic            zero_flag,
   output logic            pc_load,
   output logic            pc_inc,
   output logic            ir_load,
   output logic            ar_load,
   output logic [NREG-1:0] reg_load,
   output logic            zf_load,
   output logic [SELW-1:0] bus1_sel,
   output logic [1:0]      bus2_sel,
   output logic            mem_we,
   output logic            halted,
   output logic [3:0]      state_code
);

   op_class_t  cls;
   seq_state_t state;
   bus2_src_t  b2;

   spm_opdecode #(.OPW(OPW), .BRZ_ON_SET(BRZ_ON_SET)) u_dec (
      .opcode    (ir_opcode),
      .zero_flag (zero_flag),
      .op_class  (cls)
   );

   spm_nextstate u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_class (cls),
      .state    (state)
   );

   spm_strobes #(.REGW(REGW)) u_out (
      .state    (state),
      .op_class (cls),
      .src      (ir_src),
      .dst      (ir_dst),
      .pc_load  (pc_load),
      .pc_inc   (pc_inc),
      .ir_load  (ir_load),
      .ar_load  (ar_load),
      .reg_load (reg_load),
      .zf_load  (zf_load),
      .bus1_sel (bus1_sel),
      .bus2_sel (b2),
      .mem_we   (mem_we),
      .halted   (halted)
   );

   assign bus2_sel   = b2;
   assign state_code = state;

   // R2
   ir_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |=> (state_code == 4'd3));

   // R7
   we_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(state_code) == 4'd7));

   // R8
   pc_load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (state_code == 4'd1));

   // R4
   zf_only_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zf_load |-> (bus2_sel == 2'd0 && $countones(reg_load) == 1));

   // R11
   regload_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_load));

endmodule

// File: tb/spm_sequencer_tb.sv
module spm_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] ir_opcode;
   logic [1:0] ir_src;
   logic [1:0] ir_dst;
   logic       zero_flag;
   logic       pc_load, pc_inc, ir_load, ar_load, zf_load, mem_we, halted;
   logic [3:0] reg_load;
   logic [2:0] bus1_sel;
   logic [1:0] bus2_sel;
   logic [3:0] state_code;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spm_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_src(ir_src),
      .ir_dst(ir_dst), .zero_flag(zero_flag), .pc_load(pc_load),
      .pc_inc(pc_inc), .ir_load(ir_load), .ar_load(ar_load),
      .reg_load(reg_load), .zf_load(zf_load), .bus1_sel(bus1_sel),
      .bus2_sel(bus2_sel), .mem_we(mem_we), .halted(halted),
      .state_code(state_code)
   );

   // {pc_load,pc_inc,ir_load,ar_load,zf_load,mem_we,halted,reg_load,bus1_sel,bus2_sel}
   function automatic logic [15:0] cv(input logic pld, input logic pin, input logic irl,
                                      input logic arl, input logic zfl, input logic we,
                                      input logic hlt, input logic [3:0] rl,
                                      input logic [2:0] b1, input logic [1:0] b2);
      return {pld, pin, irl, arl, zfl, we, hlt, rl, b1, b2};
   endfunction

   task automatic chk(input string req, input logic [3:0] est, input logic [15:0] ev);
      logic [15:0] act;
      act = {pc_load, pc_inc, ir_load, ar_load, zf_load, mem_we, halted,
             reg_load, bus1_sel, bus2_sel};
      vectors++;
      if (state_code !== est || act !== ev) begin
         fails++;
         $display("FAIL %s: state %0d ctrl %h, expected state %0d ctrl %h",
                  req, state_code, act, est, ev);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // fetch1 and fetch2, leaves the bench in decode
   task automatic do_fetch();
      chk("R2 fetch1", 4'd1, cv(0,0,0,1,0,0,0,4'b0,3'd4,2'd0));
      tick();
      chk("R2 fetch2", 4'd2, cv(0,1,1,0,0,0,0,4'b0,3'd0,2'd2));
      tick();
   endtask

   task automatic load_ir(input logic [3:0] op, input logic [1:0] s,
                          input logic [1:0] d, input logic z);
      ir_opcode = op; ir_src = s; ir_dst = d; zero_flag = z;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      load_ir(4'd0, 2'd0, 2'd0, 1'b0);
      tick(); tick();
      chk("R1 in reset", 4'd0, cv(0,0,0,0,0,0,0,4'b0,3'd0,2'd0));
      rst_n = 1'b1;
      chk("R1 released", 4'd0, cv(0,0,0,0,0,0,0,4'b0,3'd0,2'd0));
      tick();
   endtask

   task automatic t_nop();
      load_ir(4'd0, 2'd2, 2'd3, 1'b1);
      do_fetch();
      chk("R3 nop decode", 4'd3, cv(0,0,0,0,0,0,0,4'b0,3'd0,2'd0));
      tick();
   endtask

   task automatic t_alu(input logic [3:0] op, input logic [1:0] s, input logic [1:0] d);
      load_ir(op, s, d, 1'b0);
      do_fetch();
      chk("R4 alu decode", 4'd3, cv(0,0,0,0,0,0,0,4'b0,{1'b0,s},2'd0));
      tick();
      chk("R4 alu execute", 4'd4, cv(0,0,0,0,1,0,0,4'b1 << d,{1'b0,s},2'd0));
      tick();
   endtask

   task automatic t_rd(input logic [1:0] d);
      load_ir(4'd5, 2'd1, d, 1'b0);
      do_fetch();
      chk("R5 read decode", 4'd3, cv(0,0,0,1,0,0,0,4'b0,3'd4,2'd0));
      tick();
      chk("R5 read addr", 4'd5, cv(0,1,0,1,0,0,0,4'b0,3'd0,2'd2));
      tick();
      chk("R6 read data", 4'd6, cv(0,0,0,0,0,0,0,4'b1 << d,3'd0,2'd2));
      tick();
   endtask

   task automatic t_wr(input logic [1:0] s);
      load_ir(4'd6, s, 2'd0, 1'b1);
      do_fetch();
      chk("R5 write decode", 4'd3, cv(0,0,0,1,0,0,0,4'b0,3'd4,2'd0));
      tick();
      chk("R5 write addr", 4'd7, cv(0,1,0,1,0,0,0,4'b0,3'd0,2'd2));
      tick();
      chk("R7 write data", 4'd8, cv(0,0,0,0,0,1,0,4'b0,{1'b0,s},2'd0));
      tick();
   endtask

   task automatic t_branch(input logic [3:0] op, input logic z, input string req);
      load_ir(op, 2'd0, 2'd0, z);
      do_fetch();
      chk(req, 4'd3, cv(0,0,0,1,0,0,0,4'b0,3'd4,2'd0));
      tick();
      chk("R5 branch addr", 4'd9, cv(0,1,0,1,0,0,0,4'b0,3'd0,2'd2));
      tick();
      chk("R8 branch target", 4'd10, cv(1,0,0,0,0,0,0,4'b0,3'd0,2'd2));
      tick();
   endtask

   task automatic t_brz_skip();
      load_ir(4'd8, 2'd1, 2'd1, 1'b0);
      do_fetch();
      chk("R9 brz not taken decode", 4'd3, cv(0,1,0,0,0,0,0,4'b0,3'd0,2'd0));
      tick();
   endtask

   task automatic t_halt(input logic [3:0] op);
      load_ir(op, 2'd1, 2'd2, 1'b0);
      do_fetch();
      chk("R10 bad opcode decode", 4'd3, cv(0,0,0,0,0,0,0,4'b0,3'd0,2'd0));
      tick();
      chk("R10 halt entered", 4'd11, cv(0,0,0,0,0,0,1,4'b0,3'd0,2'd0));
      for (int i = 0; i < 4; i++) begin
         load_ir(4'(i + 1), 2'(i), 2'(i), i[0]);
         tick();
         chk("R10 halt held", 4'd11, cv(0,0,0,0,0,0,1,4'b0,3'd0,2'd0));
      end
      rst_n = 1'b0;
      #1;
      chk("R1 reset from halt", 4'd0, cv(0,0,0,0,0,0,0,4'b0,3'd0,2'd0));
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      t_reset();
      t_nop();
      t_alu(4'd1, 2'd2, 2'd1);
      t_alu(4'd2, 2'd3, 2'd0);
      t_alu(4'd3, 2'd0, 2'd3);
      t_alu(4'd4, 2'd1, 2'd2);
      t_rd(2'd3);
      t_rd(2'd0);
      t_wr(2'd1);
      t_wr(2'd3);
      t_branch(4'd7, 1'b0, "R5 branch decode");
      t_branch(4'd8, 1'b1, "R9 brz taken decode");
      t_brz_skip();
      t_nop();
      t_halt(4'd12);
      t_nop();
      t_halt(4'd9);
      t_halt(4'd15);
      t_alu(4'd1, 2'd0, 2'd0);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule